// File: doc/BRIEF.md
# Nonvolatile Memory Command Status Register

This block is the 8-bit status and launch register of an on-chip nonvolatile memory controller. A host bus reads it at any time and writes it to start a command: writing 1 to the completion flag clears that flag and, if no error is pending, sends a one-cycle start pulse to an external command engine. The engine reports back through plain inputs: a busy level, a done pulse with a 2-bit result code, and pulses for protection violations and access errors. The register turns these into flags.

The two error flags are sticky and cleared by writing 1. While either one is set, a launch request is refused: there is no start pulse and the completion flag stays 1. The completion flag drives an interrupt output through an external enable. The block has no data stream, so there is no valid/ready handshake. Every pin is a plain control or status level or pulse.

Read layout (bit positions are fixed): bit 7 completion flag, bit 6 reads 0, bit 5 access error, bit 4 protection violation, bit 3 busy, bit 2 reads 0, bits 1:0 result code.

Top module: `nvm_cmd_stat`

## Requirements
- R1: After reset the read value is 0x80, with the completion flag at 1 and all other bits at 0, and the start pulse is low.
- R2: A write with bit 7 = 1, while the completion flag is 1 and both error flags are 0, raises the start output for exactly the next cycle. From that same cycle the completion flag reads 0.
- R3: A launch request while the access-error flag (bit 5) is set gives no start pulse, and the completion flag stays 1.
- R4: A launch request while the protection flag (bit 4) is set gives no start pulse, and the completion flag stays 1.
- R5: Writing 1 to bit 5, bit 4, bit 1 or bit 0 clears that bit. Writing 0 to any bit leaves the register unchanged.
- R6: A done pulse while a command runs sets the completion flag to 1 in the next cycle and loads the 2-bit result code into bits 1:0.
- R7: Launching a command clears bits 1:0 to 0.
- R8: An access-error or protection input pulse sets its flag in the next cycle, even when the same cycle writes 1 to clear it. If a command is running, the pulse also returns the completion flag to 1.
- R9: Bit 3 reads the engine busy input. Bits 6 and 2 always read 0.
- R10: The interrupt output equals the completion flag ANDed with the interrupt-enable input.
- R11: Writing bit 7 = 1 while a command runs does not produce a second start pulse. A done pulse while idle changes nothing.
- R12: The launch decision uses the error flags as they were before the write. A single write that sets bits 7 and 5 clears the access error but does not launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Register read value |
| irq_en | input | 1 | Completion interrupt enable |
| irq | output | 1 | Completion interrupt |
| eng_start | output | 1 | One-cycle command start pulse to the engine |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Engine command-finished pulse |
| eng_result | input | 2 | Result code, valid with eng_done |
| eng_prot_err | input | 1 | Protection violation pulse |
| eng_acc_err | input | 1 | Access error pulse |

## Verification
The bench goes after the launch gate. It requests launches with each error flag set in turn, and it sends a single write that clears the access error while asking for a launch. A design that gates on the post-write flags would start a command there. It also re-requests a launch while a command is running, which a design without the idle check would answer with a second start pulse. The bench also drives an error pulse in the same cycle as a clearing write, and sends a done pulse while idle. Getting the priority wrong in the first case loses the error. Getting the second wrong corrupts the result bits.

// File: rtl/nvm_stat_pkg.sv
package nvm_stat_pkg;
  localparam int REG_W    = 8;
  localparam int RES_W    = 2;
  localparam int N_ERR    = 2;
  localparam int POS_CCF  = 7;
  localparam int POS_ACC  = 5;
  localparam int POS_PROT = 4;
  localparam int POS_BUSY = 3;

  // bit position of error flag i (0: access error, 1: protection)
  function automatic int err_pos(input int idx);
    return (idx == 0) ? POS_ACC : POS_PROT;
  endfunction
endpackage

// File: rtl/nvm_sticky_flag.sv
module nvm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/nvm_launch_gate.sv
module nvm_launch_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_go,
  input  logic idle,
  input  logic err_any,
  output logic launch,
  output logic start_o
);
  assign launch = wr_en & wr_go & idle & ~err_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_o <= 1'b0;
    else        start_o <= launch;
  end
endmodule

// File: rtl/nvm_cmd_tracker.sv
module nvm_cmd_tracker #(
  parameter int RES_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             done_in,
  input  logic [RES_W-1:0] result_in,
  input  logic             violation,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wr_clr,
  output logic             ccf_o,
  output logic [RES_W-1:0] res_o
);
  logic running;
  assign running = ~ccf_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccf_o <= 1'b1;
      res_o <= '0;
    end else begin
      if (launch)                            ccf_o <= 1'b0;
      else if (running && (done_in || violation)) ccf_o <= 1'b1;

      if (launch)                   res_o <= '0;
      else if (running && done_in)  res_o <= result_in;
      else if (wr_en)               res_o <= res_o & ~wr_clr;
    end
  end
endmodule

// File: rtl/nvm_cmd_stat.sv
module nvm_cmd_stat
  import nvm_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             irq_en,
  output logic             irq,
  output logic             eng_start,
  input  logic             eng_busy,
  input  logic             eng_done,
  input  logic [RES_W-1:0] eng_result,
  input  logic             eng_prot_err,
  input  logic             eng_acc_err
);
  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_q;
  logic             ccf;
  logic [RES_W-1:0] res;
  logic             launch;
  logic             unused_wr_bits;

  assign err_set = {eng_prot_err, eng_acc_err};
  assign unused_wr_bits = ^{wr_data[6], wr_data[POS_BUSY], wr_data[2]};

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    nvm_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (err_set[i]),
      .clr_i (wr_en & wr_data[err_pos(i)]),
      .q_o   (err_q[i])
    );
  end

  nvm_launch_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_go   (wr_data[POS_CCF]),
    .idle    (ccf),
    .err_any (|err_q),
    .launch  (launch),
    .start_o (eng_start)
  );

  nvm_cmd_tracker #(.RES_W(RES_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .done_in   (eng_done),
    .result_in (eng_result),
    .violation (|err_set),
    .wr_en     (wr_en),
    .wr_clr    (wr_data[RES_W-1:0]),
    .ccf_o     (ccf),
    .res_o     (res)
  );

  always_comb begin
    rd_data                = '0;
    rd_data[POS_CCF]       = ccf;
    rd_data[POS_ACC]       = err_q[0];
    rd_data[POS_PROT]      = err_q[1];
    rd_data[POS_BUSY]      = eng_busy;
    rd_data[RES_W-1:0]     = res;
  end

  assign irq = ccf & irq_en;
endmodule

// File: rtl/nvm_cmd_stat_chk.sv
module nvm_cmd_stat_chk
  import nvm_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_en,
  input logic             irq,
  input logic             eng_start,
  input logic             eng_busy,
  input logic             eng_done,
  input logic [RES_W-1:0] eng_result,
  input logic             eng_prot_err,
  input logic             eng_acc_err
);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  a_r2_start_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !rd_data[POS_CCF]);
  a_r3_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[POS_CCF] && (rd_data[POS_ACC] || rd_data[POS_PROT])) |=> !eng_start);
  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !rd_data[POS_CCF]) |=> (rd_data[POS_CCF] && rd_data[RES_W-1:0] == $past(eng_result)));
  a_r7_result_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (rd_data[RES_W-1:0] == '0));
  a_r8_acc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eng_acc_err |=> rd_data[POS_ACC]);
  a_r8_prot_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eng_prot_err |=> rd_data[POS_PROT]);
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[6] && !rd_data[2]));
  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[POS_CCF] && irq_en));
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[POS_CCF]) |=> !eng_start);
endmodule

bind nvm_cmd_stat nvm_cmd_stat_chk u_chk (.*);

// File: tb/nvm_cmd_stat_tb.sv
module nvm_cmd_stat_tb;
  typedef struct {
    logic [7:0] rd;
    logic       start;
    logic       irq;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_en = 1'b0;
  logic       irq;
  logic       eng_start;
  logic       eng_busy = 1'b0;
  logic       eng_done = 1'b0;
  logic [1:0] eng_result = '0;
  logic       eng_prot_err = 1'b0;
  logic       eng_acc_err = 1'b0;

  int total = 0;
  int bad = 0;
  exp_t sb[$];

  // model state
  logic       m_ccf = 1'b1, m_acc = 1'b0, m_prot = 1'b0;
  logic [1:0] m_res = '0;

  always #10 clk = ~clk;

  nvm_cmd_stat u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_en(irq_en), .irq(irq), .eng_start(eng_start), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_result(eng_result), .eng_prot_err(eng_prot_err),
    .eng_acc_err(eng_acc_err)
  );

  task automatic check(input string tag, input logic [7:0] a_rd, input logic a_st, input logic a_irq,
                       input logic [7:0] e_rd, input logic e_st, input logic e_irq);
    total++;
    if (a_rd !== e_rd || a_st !== e_st || a_irq !== e_irq) begin
      bad++;
      $display("FAIL %s: actual rd=%02h start=%0b irq=%0b expected rd=%02h start=%0b irq=%0b",
               tag, a_rd, a_st, a_irq, e_rd, e_st, e_irq);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed for the monitor
  task automatic step(input logic we, input logic [7:0] d, input logic dn, input logic [1:0] rs,
                      input logic pe, input logic ae, input logic bz, input logic ie, input string tag);
    logic launch;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = d; eng_done = dn; eng_result = rs;
    eng_prot_err = pe; eng_acc_err = ae; eng_busy = bz; irq_en = ie;
    launch = we && d[7] && m_ccf && !m_acc && !m_prot;
    if (launch) m_res = 2'b00;
    else if (!m_ccf && dn) m_res = rs;
    else if (we) m_res = m_res & ~d[1:0];
    if (launch) m_ccf = 1'b0;
    else if (!m_ccf && (dn || pe || ae)) m_ccf = 1'b1;
    m_acc  = ae | (m_acc  & !(we && d[5]));
    m_prot = pe | (m_prot & !(we && d[4]));
    e.rd = {m_ccf, 1'b0, m_acc, m_prot, bz, 1'b0, m_res};
    e.start = launch;
    e.irq = m_ccf & ie;
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  // monitor: sample mid-cycle after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, rd_data, eng_start, irq, e.rd, e.start, e.irq);
      end
    end
  end

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset", rd_data, eng_start, irq, 8'h80, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 8'h00, 0, 2'b00, 0, 0, 0, 1, "R10 irq with enable");
    step(1, 8'h80, 0, 2'b00, 0, 0, 1, 1, "R2 launch");
    step(1, 8'h80, 0, 2'b00, 0, 0, 1, 1, "R11 relaunch while running");
    step(0, 8'h00, 1, 2'b01, 0, 0, 0, 1, "R6 done loads result");
    step(1, 8'h80, 0, 2'b00, 0, 0, 1, 1, "R7 launch clears result");
    step(0, 8'h00, 0, 2'b00, 0, 1, 0, 1, "R8 access error ends command");
    step(1, 8'h80, 0, 2'b00, 0, 0, 0, 1, "R3 launch blocked by access error");
    step(1, 8'h00, 0, 2'b00, 0, 0, 0, 1, "R5 write zero no effect");
    step(1, 8'ha0, 0, 2'b00, 0, 0, 0, 1, "R12 clear and launch together");
    step(1, 8'h80, 0, 2'b00, 0, 0, 1, 1, "R2 launch after clear");
    step(0, 8'h00, 0, 2'b00, 1, 0, 0, 1, "R8 protection ends command");
    step(1, 8'h80, 0, 2'b00, 0, 0, 0, 1, "R4 launch blocked by protection");
    step(1, 8'h10, 0, 2'b00, 1, 0, 0, 1, "R8 set beats clear");
    step(1, 8'h10, 0, 2'b00, 0, 0, 0, 0, "R5 clear protection");
    step(1, 8'h80, 0, 2'b00, 0, 0, 1, 0, "R10 launch irq disabled");
    step(0, 8'h00, 1, 2'b11, 0, 0, 0, 0, "R6 done result 3");
    step(0, 8'h00, 1, 2'b10, 0, 0, 0, 1, "R11 done while idle ignored");
    step(1, 8'h01, 0, 2'b00, 0, 0, 1, 1, "R5 clear result bit0, R9 busy mirror");
    step(1, 8'h4e, 0, 2'b00, 0, 0, 0, 1, "R9 reserved bits read zero");
    step(1, 8'hff, 0, 2'b00, 0, 0, 0, 1, "R2 launch with all ones");
    step(0, 8'h00, 0, 2'b00, 0, 0, 0, 1, "R2 start pulse one cycle");
    step(0, 8'h00, 1, 2'b00, 0, 0, 0, 1, "R6 done result 0");
    @(negedge clk);
    wr_en = 1'b0; eng_done = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule